// File: doc/BRIEF.md
# SCSI Initiator Command Decoder

This block sits behind the command register of a small SCSI initiator controller. Each byte that the host writes there is split into a mode flag (bit 7, DMA when set) and a seven-bit opcode. The decoder then applies that opcode's fixed set of updates to the controller's readable status, interrupt, sequence-step and FIFO-flag registers, and drives the interrupt line. Select commands probe a target and record the outcome. Transfer commands either finish a stopped selection or start a data transfer.

Select commands depend on the DMA-enable input. When a select arrives while DMA enable is low, the decoder parks it. The parked select runs in the cycle in which DMA enable rises. A configuration input can suppress the interrupt that a bus-reset command would raise. The target side is external. During a probe, the decoder presents the target ID and expects two answers in the same cycle: whether the target responded, and which data direction it reports.

Top module: `scsi_cmd_decoder`

## Requirements
- R1: After reset every output is zero. Bit 7 of `status_o` always mirrors `irq_o`, and `status_o[6:0]` holds the status code.
- R2: A command byte with bit 7 set loads `tc_o` from `tc_wr` and enters DMA mode. A byte with bit 7 clear enters programmed-I/O mode and leaves `tc_o` unchanged.
- R3: Opcode 0x01 (flush) sets the interrupt code to 0x08 and clears the sequence step and the FIFO flags. It leaves the interrupt line unchanged.
- R4: Opcode 0x03 (bus reset) sets the interrupt code to 0x80. It raises the interrupt only while `rst_irq_mask` is low.
- R5: Opcode 0x12 (message accept) sets the interrupt code to 0x20, clears the sequence step and flags, and raises the interrupt. Opcode 0x18 (pad) sets the status code to 0x10, the interrupt code to 0x08 and the sequence step to 0, and leaves the interrupt line unchanged.
- R6: A select (0x41, 0x42 or 0x43) to a target that does not respond sets the status code to 0, the interrupt code to 0x20 and the sequence step to 0, and raises the interrupt.
- R7: A select 0x41 or 0x42 to a target that responds sets the interrupt code to 0x18, the sequence step to 4 and the status code to 0x10 plus the reported direction (1 for data in, 0 for data out). It raises the interrupt.
- R8: Select-and-stop 0x43 to a target that responds sets the status code to 0x12, the interrupt code to 0x18 and the sequence step to 4, raises the interrupt, and waits for the command bytes. The next transfer command (0x10) then probes again and gives the result of R6 or R7.
- R9: A select written while `dma_en` is low changes no register. It runs in the cycle where `dma_en` goes from low to high, and its result appears one cycle later. A command written in that same cycle is dropped.
- R10: An opcode outside the defined set (0x00, 0x01, 0x02, 0x03, 0x10, 0x11, 0x12, 0x18, 0x1A, 0x41 to 0x44) leaves every register unchanged, including `tc_o`. It gives a one-cycle pulse on `err_o` in the cycle after the write.
- R11: Opcode 0x02 (reset) returns every register to its reset value and discards a parked select.
- R12: `intr_ack` clears the interrupt code, clears status bit 4, sets the sequence step to 4 and lowers the interrupt line. A command in the same cycle takes effect on top of the acknowledge.
- R13: Opcode 0x11 (complete) sets the interrupt code to 0x08 and raises the interrupt. In DMA mode it also sets the status code to 0x17 and the sequence step to 4. In programmed-I/O mode it sets status bits 2:0 and sets the flags to 2.
- R14: A transfer command with no select waiting gives a one-cycle pulse on `xfer_go`, and in DMA mode it also clears status bit 4. Opcode 0x44 clears the interrupt code. Opcodes 0x00 and 0x1A change nothing beyond the effect of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_we | input | 1 | Command register write strobe |
| cmd_byte | input | 8 | Command byte; bit 7 is the DMA flag |
| tc_wr | input | TC_W | Written transfer-count value |
| bus_id | input | ID_W | Target ID used by select commands |
| rst_irq_mask | input | 1 | Suppresses the bus-reset interrupt when high |
| dma_en | input | 1 | DMA enable from the system |
| intr_ack | input | 1 | Interrupt-register read strobe |
| tgt_present | input | 1 | Probed target responded (same cycle as probe) |
| tgt_dir_in | input | 1 | Probed target reports data-in |
| sel_probe | output | 1 | A target probe happens this cycle |
| probe_id | output | ID_W | ID being probed, zero otherwise |
| status_o | output | 8 | Status register (bit 7 = interrupt) |
| intr_o | output | 8 | Interrupt register |
| seq_o | output | 3 | Sequence step |
| flags_o | output | 5 | FIFO flags |
| tc_o | output | TC_W | Readable transfer count |
| irq_o | output | 1 | Interrupt line |
| xfer_go | output | 1 | Data transfer start pulse |
| err_o | output | 1 | Unknown opcode pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit transfer count and a 3-bit target ID. These values cover the reload of full-width counts and all eight target IDs, each with its own presence and direction setting in the responder. A random phase mixes every opcode, both mode flags and undefined codes with toggling DMA enable. This drives parked selects into edge cycles that collide with acknowledges and with fresh writes.

// File: rtl/scsi_dec_pkg.sv
package scsi_dec_pkg;

    typedef enum logic [3:0] {
        K_NONE, K_FLUSH, K_RESET, K_BUSRST, K_XFER, K_CMPL,
        K_MSGOK, K_PAD, K_SEL, K_SELSTOP, K_RESEL, K_BAD
    } op_kind_e;

    localparam logic [7:0] IC_FUNC_DONE = 8'h08;
    localparam logic [7:0] IC_BUS_SVC   = 8'h10;
    localparam logic [7:0] IC_DISCON    = 8'h20;
    localparam logic [7:0] IC_BUS_RST   = 8'h80;

    localparam logic [6:0] SC_TERM      = 7'h10;
    localparam logic [6:0] SC_CMD_PH    = 7'h02;
    localparam logic [6:0] SC_MSG_IN    = 7'h07;

    localparam logic [2:0] STEP_CMD     = 3'd4;

endpackage

// File: rtl/scsi_op_classify.sv
module scsi_op_classify
    import scsi_dec_pkg::*;
(
    input  logic [6:0] op,
    output op_kind_e   kind
);
    always_comb begin
        unique case (op)
            7'h00, 7'h1A: kind = K_NONE;
            7'h01:        kind = K_FLUSH;
            7'h02:        kind = K_RESET;
            7'h03:        kind = K_BUSRST;
            7'h10:        kind = K_XFER;
            7'h11:        kind = K_CMPL;
            7'h12:        kind = K_MSGOK;
            7'h18:        kind = K_PAD;
            7'h41, 7'h42: kind = K_SEL;
            7'h43:        kind = K_SELSTOP;
            7'h44:        kind = K_RESEL;
            default:      kind = K_BAD;
        endcase
    end
endmodule

// File: rtl/scsi_sel_park.sv
module scsi_sel_park (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic park,
    input  logic park_stop,
    input  logic dma_en,
    output logic fire_pend,
    output logic pend_stop
);
    typedef struct packed {
        logic held;
        logic stop;
        logic en_prev;
    } park_t;

    park_t p_d, p_q;

    assign fire_pend = p_q.held & dma_en & ~p_q.en_prev;
    assign pend_stop = p_q.stop;

    always_comb begin
        p_d = p_q;
        p_d.en_prev = dma_en;
        if (clear || fire_pend) begin
            p_d.held = 1'b0;
        end else if (park) begin
            p_d.held = 1'b1;
            p_d.stop = park_stop;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end
endmodule

// File: rtl/scsi_cmd_decoder.sv
module scsi_cmd_decoder
    import scsi_dec_pkg::*;
#(
    parameter int TC_W = 16,
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_we,
    input  logic [7:0]      cmd_byte,
    input  logic [TC_W-1:0] tc_wr,
    input  logic [ID_W-1:0] bus_id,
    input  logic            rst_irq_mask,
    input  logic            dma_en,
    input  logic            intr_ack,
    input  logic            tgt_present,
    input  logic            tgt_dir_in,
    output logic            sel_probe,
    output logic [ID_W-1:0] probe_id,
    output logic [7:0]      status_o,
    output logic [7:0]      intr_o,
    output logic [2:0]      seq_o,
    output logic [4:0]      flags_o,
    output logic [TC_W-1:0] tc_o,
    output logic            irq_o,
    output logic            xfer_go,
    output logic            err_o
);
    localparam int STAT_W = 7;

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [7:0]        intr;
        logic [2:0]        seq;
        logic [4:0]        flags;
        logic [TC_W-1:0]   tc;
        logic              dma;
        logic              irq;
        logic              await_cmd;
        logic              xfer;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;

    op_kind_e kind;
    logic     fire_pend, pend_stop;
    logic     is_sel, take_cmd, park, fire_now, ti_probe;
    logic     soft_rst;

    scsi_op_classify u_cls (
        .op   (cmd_byte[6:0]),
        .kind (kind)
    );

    assign is_sel   = (kind == K_SEL) || (kind == K_SELSTOP);
    assign take_cmd = cmd_we && !fire_pend && (kind != K_BAD);
    assign park     = take_cmd && is_sel && !dma_en;
    assign fire_now = take_cmd && is_sel && dma_en;
    assign ti_probe = take_cmd && (kind == K_XFER) && r_q.await_cmd;
    assign soft_rst = take_cmd && (kind == K_RESET);

    scsi_sel_park u_park (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (soft_rst),
        .park      (park),
        .park_stop (kind == K_SELSTOP),
        .dma_en    (dma_en),
        .fire_pend (fire_pend),
        .pend_stop (pend_stop)
    );

    assign sel_probe = fire_pend || fire_now || ti_probe;
    assign probe_id  = sel_probe ? bus_id : '0;

    always_comb begin
        logic stop_req;
        r_d      = r_q;
        r_d.err  = 1'b0;
        r_d.xfer = 1'b0;
        stop_req = fire_pend ? pend_stop : (fire_now && kind == K_SELSTOP);

        if (intr_ack) begin
            r_d.intr    = '0;
            r_d.stat[4] = 1'b0;
            r_d.seq     = STEP_CMD;
            r_d.irq     = 1'b0;
        end

        if (cmd_we && !fire_pend && kind == K_BAD) begin
            r_d.err = 1'b1;
        end else if (take_cmd) begin
            r_d.dma = cmd_byte[7];
            if (cmd_byte[7]) r_d.tc = tc_wr;
            unique case (kind)
                K_FLUSH: begin
                    r_d.intr  = IC_FUNC_DONE;
                    r_d.seq   = '0;
                    r_d.flags = '0;
                end
                K_RESET:  r_d = '0;
                K_BUSRST: begin
                    r_d.intr = IC_BUS_RST;
                    if (!rst_irq_mask) r_d.irq = 1'b1;
                end
                K_XFER: begin
                    if (!r_q.await_cmd) begin
                        r_d.xfer = 1'b1;
                        if (cmd_byte[7]) r_d.stat[4] = 1'b0;
                    end
                end
                K_CMPL: begin
                    r_d.intr = IC_FUNC_DONE;
                    r_d.irq  = 1'b1;
                    if (cmd_byte[7]) begin
                        r_d.stat = SC_TERM | SC_MSG_IN;
                        r_d.seq  = STEP_CMD;
                    end else begin
                        r_d.stat  = r_d.stat | SC_MSG_IN;
                        r_d.flags = 5'd2;
                    end
                end
                K_MSGOK: begin
                    r_d.intr  = IC_DISCON;
                    r_d.seq   = '0;
                    r_d.flags = '0;
                    r_d.irq   = 1'b1;
                end
                K_PAD: begin
                    r_d.stat = SC_TERM;
                    r_d.intr = IC_FUNC_DONE;
                    r_d.seq  = '0;
                end
                K_RESEL: r_d.intr = '0;
                default: ;
            endcase
        end

        if (sel_probe) begin
            r_d.await_cmd = 1'b0;
            r_d.irq       = 1'b1;
            if (!tgt_present) begin
                r_d.stat = '0;
                r_d.intr = IC_DISCON;
                r_d.seq  = '0;
            end else begin
                r_d.intr = IC_BUS_SVC | IC_FUNC_DONE;
                r_d.seq  = STEP_CMD;
                if (stop_req) begin
                    r_d.stat      = SC_TERM | SC_CMD_PH;
                    r_d.await_cmd = 1'b1;
                end else begin
                    r_d.stat = SC_TERM | {6'd0, tgt_dir_in};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign status_o = {r_q.irq, r_q.stat};
    assign intr_o   = r_q.intr;
    assign seq_o    = r_q.seq;
    assign flags_o  = r_q.flags;
    assign tc_o     = r_q.tc;
    assign irq_o    = r_q.irq;
    assign xfer_go  = r_q.xfer;
    assign err_o    = r_q.err;
endmodule

// File: rtl/scsi_cmd_decoder_chk.sv
module scsi_cmd_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_we,
    input logic [7:0] cmd_byte,
    input logic       rst_irq_mask,
    input logic       dma_en,
    input logic       intr_ack,
    input logic       tgt_present,
    input logic       sel_probe,
    input logic       fire_pend,
    input logic [7:0] status_o,
    input logic [7:0] intr_o,
    input logic [2:0] seq_o,
    input logic       irq_o,
    input logic       err_o
);
    logic op_known;
    always_comb begin
        case (cmd_byte[6:0])
            7'h00, 7'h01, 7'h02, 7'h03, 7'h10, 7'h11, 7'h12, 7'h18,
            7'h1A, 7'h41, 7'h42, 7'h43, 7'h44: op_known = 1'b1;
            default: op_known = 1'b0;
        endcase
    end

    AST_STATUS_MIRRORS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[7] == irq_o); // R1

    AST_BUSRST_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && !fire_pend && cmd_byte[6:0] == 7'h03 && rst_irq_mask && !irq_o
        |=> !irq_o && intr_o == 8'h80); // R4

    AST_SEL_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        sel_probe && !tgt_present |=> status_o == 8'h80 && intr_o == 8'h20 && seq_o == 3'd0); // R6

    AST_SEL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        sel_probe && tgt_present |=> irq_o && intr_o == 8'h18 && seq_o == 3'd4); // R7

    AST_PROBE_NEEDS_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        sel_probe && !(cmd_we && cmd_byte[6:0] == 7'h10) |-> dma_en); // R9

    AST_BAD_OP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we && !fire_pend && !op_known && !intr_ack
        |=> err_o && $stable(intr_o) && $stable(status_o) && $stable(seq_o)); // R10

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        intr_ack && !cmd_we && !fire_pend |=> !irq_o && intr_o == 8'h00 && seq_o == 3'd4); // R12
endmodule

bind scsi_cmd_decoder scsi_cmd_decoder_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_we       (cmd_we),
    .cmd_byte     (cmd_byte),
    .rst_irq_mask (rst_irq_mask),
    .dma_en       (dma_en),
    .intr_ack     (intr_ack),
    .tgt_present  (tgt_present),
    .sel_probe    (sel_probe),
    .fire_pend    (fire_pend),
    .status_o     (status_o),
    .intr_o       (intr_o),
    .seq_o        (seq_o),
    .irq_o        (irq_o),
    .err_o        (err_o)
);

// File: tb/scsi_cmd_decoder_test.sv
module scsi_cmd_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we = 1'b0;
    logic [7:0]  cmd_byte = 8'h00;
    logic [15:0] tc_wr = 16'h0000;
    logic [2:0]  bus_id = 3'd0;
    logic        rst_irq_mask = 1'b0;
    logic        dma_en = 1'b1;
    logic        intr_ack = 1'b0;
    logic        tgt_present, tgt_dir_in, sel_probe;
    logic [2:0]  probe_id;
    logic [7:0]  status_o, intr_o;
    logic [2:0]  seq_o;
    logic [4:0]  flags_o;
    logic [15:0] tc_o;
    logic        irq_o, xfer_go, err_o;

    // responder: targets 1,2,3,6 answer; 2 and 6 report data-in
    logic [7:0] pres_mask = 8'b0100_1110;
    logic [7:0] din_mask  = 8'b0100_0100;
    assign tgt_present = pres_mask[probe_id];
    assign tgt_dir_in  = din_mask[probe_id];

    always #5 clk = ~clk;

    scsi_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
        .tc_wr(tc_wr), .bus_id(bus_id), .rst_irq_mask(rst_irq_mask),
        .dma_en(dma_en), .intr_ack(intr_ack), .tgt_present(tgt_present),
        .tgt_dir_in(tgt_dir_in), .sel_probe(sel_probe), .probe_id(probe_id),
        .status_o(status_o), .intr_o(intr_o), .seq_o(seq_o), .flags_o(flags_o),
        .tc_o(tc_o), .irq_o(irq_o), .xfer_go(xfer_go), .err_o(err_o)
    );

    int total = 0;
    int bad = 0;
    string tag = "R1";

    // behavioural reference state
    int  e_stat, e_intr, e_seq, e_flags, e_tc;
    bit  e_dma, e_irq, e_wait, e_xfer, e_err, e_held, e_hstop, e_dprev;

    task automatic model_clear();
        e_stat = 0; e_intr = 0; e_seq = 0; e_flags = 0; e_tc = 0;
        e_dma = 0; e_irq = 0; e_wait = 0; e_xfer = 0; e_err = 0;
        e_held = 0; e_hstop = 0;
    endtask

    task automatic probe_result(bit stop);
        e_wait = 0;
        e_irq  = 1;
        if (!pres_mask[bus_id]) begin
            e_stat = 0; e_intr = 'h20; e_seq = 0;
        end else begin
            e_intr = 'h18; e_seq = 4;
            if (stop) begin e_stat = 'h12; e_wait = 1; end
            else e_stat = 'h10 + din_mask[bus_id];
        end
    endtask

    task automatic model_step();
        bit edge_go;
        int op;
        edge_go = e_held && dma_en && !e_dprev;
        e_err = 0; e_xfer = 0;
        if (intr_ack) begin
            e_intr = 0; e_stat = e_stat & 'h6F; e_seq = 4; e_irq = 0;
        end
        if (edge_go) begin
            e_held = 0;
            probe_result(e_hstop);
        end else if (cmd_we) begin
            op = cmd_byte & 'h7F;
            if (!(op inside {'h00, 'h01, 'h02, 'h03, 'h10, 'h11, 'h12, 'h18, 'h1A,
                             'h41, 'h42, 'h43, 'h44})) begin
                e_err = 1;
            end else begin
                e_dma = cmd_byte[7];
                if (cmd_byte[7]) e_tc = tc_wr;
                case (op)
                    'h01: begin e_intr = 8; e_seq = 0; e_flags = 0; end
                    'h02: model_clear();
                    'h03: begin e_intr = 'h80; if (!rst_irq_mask) e_irq = 1; end
                    'h10: if (e_wait) probe_result(0);
                          else begin e_xfer = 1; if (e_dma) e_stat = e_stat & 'h6F; end
                    'h11: begin
                        e_intr = 8; e_irq = 1;
                        if (e_dma) begin e_stat = 'h17; e_seq = 4; end
                        else begin e_stat = e_stat | 7; e_flags = 2; end
                    end
                    'h12: begin e_intr = 'h20; e_seq = 0; e_flags = 0; e_irq = 1; end
                    'h18: begin e_stat = 'h10; e_intr = 8; e_seq = 0; end
                    'h41, 'h42, 'h43: begin
                        if (dma_en) probe_result(op == 'h43);
                        else begin e_held = 1; e_hstop = (op == 'h43); end
                    end
                    'h44: e_intr = 0;
                    default: ;
                endcase
            end
        end
        e_dprev = dma_en;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_clear();
            e_dprev = 0;
        end else begin
            model_step();
        end
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n) begin
            check(status_o == {e_irq, e_stat[6:0]}, tag, "status", status_o, {e_irq, e_stat[6:0]});
            check(intr_o == e_intr[7:0], tag, "intr", intr_o, e_intr);
            check(seq_o == e_seq[2:0], tag, "seq", seq_o, e_seq);
            check(flags_o == e_flags[4:0], tag, "flags", flags_o, e_flags);
            check(tc_o == e_tc[15:0], tag, "tc", tc_o, e_tc);
            check({xfer_go, err_o} == {e_xfer, e_err}, tag, "pulses", {xfer_go, err_o}, {e_xfer, e_err});
        end
    end

    task automatic issue(input logic [7:0] b);
        @(negedge clk);
        cmd_we = 1'b1; cmd_byte = b;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        intr_ack = 1'b1;
        @(negedge clk);
        intr_ack = 1'b0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R1";
        check(status_o == 8'h00 && intr_o == 8'h00 && tc_o == 16'h0 && !irq_o,
              "R1", "reset state", {status_o, intr_o}, 0);

        tag = "R2";
        tc_wr = 16'h1234; issue(8'h80);
        check(tc_o == 16'h1234, "R2", "tc reload", tc_o, 16'h1234);
        tc_wr = 16'h55AA; issue(8'h1A);
        check(tc_o == 16'h1234, "R2", "tc held in PIO", tc_o, 16'h1234);

        tag = "R13"; issue(8'h11);
        check(status_o == 8'h87 && flags_o == 5'd2 && intr_o == 8'h08, "R13", "complete PIO",
              status_o, 8'h87);
        tag = "R12"; ack();
        check(!irq_o && intr_o == 0 && seq_o == 3'd4, "R12", "ack", intr_o, 0);
        tag = "R3"; issue(8'h01);
        check(intr_o == 8'h08 && flags_o == 0 && seq_o == 0 && !irq_o, "R3", "flush", intr_o, 8);
        tag = "R13"; issue(8'h91);
        check(status_o == 8'h97 && seq_o == 3'd4, "R13", "complete DMA", status_o, 8'h97);
        ack();

        tag = "R4"; rst_irq_mask = 1'b0; issue(8'h03);
        check(irq_o && intr_o == 8'h80, "R4", "bus reset unmasked", irq_o, 1);
        ack(); rst_irq_mask = 1'b1; issue(8'h03);
        check(!irq_o && intr_o == 8'h80, "R4", "bus reset masked", irq_o, 0);

        tag = "R5"; issue(8'h12);
        check(irq_o && intr_o == 8'h20 && seq_o == 0, "R5", "message accept", intr_o, 8'h20);
        issue(8'h18);
        check(status_o == 8'h90 && intr_o == 8'h08, "R5", "pad", status_o, 8'h90);
        ack();

        tag = "R7"; bus_id = 3'd2; issue(8'h41);
        check(status_o == 8'h91 && intr_o == 8'h18 && seq_o == 3'd4, "R7", "select in", status_o, 8'h91);
        bus_id = 3'd3; issue(8'hC2);
        check(status_o == 8'h90, "R7", "select out", status_o, 8'h90);
        tag = "R6"; bus_id = 3'd5; issue(8'h42);
        check(status_o == 8'h80 && intr_o == 8'h20 && seq_o == 0, "R6", "missing", status_o, 8'h80);

        tag = "R8"; bus_id = 3'd6; ack(); issue(8'h43);
        check(status_o == 8'h92 && intr_o == 8'h18, "R8", "select stop", status_o, 8'h92);
        ack(); issue(8'h90);
        check(status_o == 8'h91 && !xfer_go, "R8", "command finish", status_o, 8'h91);

        tag = "R14"; issue(8'h90);
        check(xfer_go && status_o[4] == 1'b0, "R14", "transfer start", xfer_go, 1);
        issue(8'h44);
        check(intr_o == 0, "R14", "reselect", intr_o, 0);

        tag = "R9"; ack(); bus_id = 3'd2;
        @(negedge clk); dma_en = 1'b0;
        issue(8'h41);
        repeat (2) @(negedge clk);
        check(intr_o == 0 && !irq_o, "R9", "parked", intr_o, 0);
        dma_en = 1'b1;
        @(negedge clk);
        check(status_o == 8'h91 && intr_o == 8'h18, "R9", "resumed", status_o, 8'h91);

        tag = "R10"; issue(8'h27);
        check(err_o && status_o == 8'h91 && tc_o == 16'h55AA, "R10", "bad opcode", err_o, 1);
        @(negedge clk);
        check(!err_o, "R10", "pulse width", err_o, 0);

        tag = "R11"; dma_en = 1'b0; issue(8'h43); issue(8'h02);
        check(status_o == 0 && tc_o == 0 && intr_o == 0, "R11", "soft reset", status_o, 0);
        dma_en = 1'b1; repeat (2) @(negedge clk);
        check(!irq_o && intr_o == 0, "R11", "parked select dropped", intr_o, 0);

        tag = "R9";
        for (int i = 0; i < 3000; i++) begin
            int pick;
            @(negedge clk);
            pick = $urandom_range(0, 14);
            cmd_we = ($urandom_range(0, 2) == 0);
            cmd_byte = {1'($urandom_range(0, 1)),
                        7'(pick == 13 ? 7'h05 : pick == 14 ? 7'h45 :
                           pick < 4 ? pick : pick == 4 ? 'h10 : pick == 5 ? 'h11 :
                           pick == 6 ? 'h12 : pick == 7 ? 'h18 : pick == 8 ? 'h1A :
                           pick == 12 ? 'h44 : 'h41 + pick - 9)};
            if (cmd_byte[6:0] == 7'h02 && $urandom_range(0, 3) != 0) cmd_we = 1'b0;
            intr_ack = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 6) == 0) dma_en = ~dma_en;
            bus_id = 3'($urandom_range(0, 7));
            rst_irq_mask = 1'($urandom_range(0, 1));
            tc_wr = 16'($urandom);
        end
        @(negedge clk);
        cmd_we = 1'b0; intr_ack = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule